// File: doc/BRIEF.md
# Buffered Output-Compare Timer Bank

This block holds a bank of output-compare channels that watch a free-running nanosecond count supplied from outside. Software programs each channel through a simple register bus. A channel has a control word that selects its pin behaviour and enables its interrupt, plus a compare register. When the live count equals the channel's armed target, the channel sets its event flag. It can raise its interrupt, and it either toggles its output pin or drives a single-cycle high pulse. The pulse mode suits a pulse-per-second output.

The compare register is double-buffered. Once a target is armed, a further compare write is held as the queued target. The queued target takes over the moment the armed one fires, so software can stay one event ahead of the hardware. A shared status word collects every channel's event flag for a single-read poll. The bus offers a write strobe, a byte address, write data and a combinational read-data return. The count input is sampled on the same clock as the bus.

Top module: `oc_timer_bank`

## Requirements
- R1: Channel n's control word sits at byte address 0x08+8n and its compare register at 0x0C+8n. The control word carries the DMA-request enable in bit 0, the pin mode in bits 5:2, the interrupt enable in bit 6 and the event flag in bit 7. Bit 1 and bits 31:8 read as zero, and compare addresses and unmapped addresses read as zero. A written mode reads back in the cycle after the write.
- R2: The status word at 0x04 returns each channel's event flag in bit n, with the upper bits zero.
- R3: At a clock edge where the channel's mode is nonzero, a target is armed and the count input equals that target, the event flag is set. Writing a control word with bit 7 set clears the flag. A set and a clear in the same cycle leave the flag set.
- R4: A channel's interrupt output is high exactly while its event flag and interrupt enable are both set.
- R5: In mode 0xF the pin is high for exactly the one cycle following the edge at which the match occurred.
- R6: In mode 0x5 the pin inverts at each match edge and otherwise holds its level.
- R7: A compare write to a channel in mode 0 replaces the armed target and arms it. A write to an enabled channel with no armed target arms it. A write to an enabled channel that already has an armed target is held as the queued target, overwriting any earlier queued value.
- R8: On a match, the queued target, if present, becomes the armed target in the same cycle. Without a queued target the channel disarms, and the same value never fires twice.
- R9: In mode 0 a channel never matches and drives its pin low. Writing mode 0 discards any queued target.
- R10: Reset clears every control field, flag, pin, interrupt and armed or queued target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW (31) | Live nanosecond count |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr (combinational) |
| cmp_pin_o | output | NCH (4) | Per-channel compare output pins |
| irq_o | output | NCH (4) | Per-channel interrupt requests |

## Verification
The embedded assertions check several rules on every cycle. A match always leaves the flag set, whatever clear arrives in the same cycle. A disabled channel never gains a flag. A pulse-mode pin is high only with a flag behind it. A toggle-mode pin changes only after a match. A match without a queued target disarms, and an armed write to an enabled channel lands in the queue. Only the bench scenarios show the values on the bus. These include the exact readback encodings and the status word. They also include the ordering of armed and queued targets across several matches, the discarding of a queued value when a channel is disabled, and the absence of a second match on a spent target.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

    localparam logic [3:0] MODE_OFF    = 4'h0;
    localparam logic [3:0] MODE_TOGGLE = 4'h5;
    localparam logic [3:0] MODE_PULSE  = 4'hF;

    localparam int BIT_DRE   = 0;
    localparam int MODE_LO   = 2;
    localparam int MODE_HI   = 5;
    localparam int BIT_IE    = 6;
    localparam int BIT_FLAG  = 7;
    localparam int CTRL_W    = 8;

endpackage

// File: rtl/oc_bus_decode.sv
module oc_bus_decode #(
    parameter int NCH       = 4,
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int STAT_ADDR = 4,
    parameter int CH_BASE   = 8,
    parameter int CH_STRIDE = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_wr,
    input  logic [AW-1:0]                        bus_addr,
    input  logic [NCH-1:0][oc_timer_pkg::CTRL_W-1:0] ctrl_rd,
    input  logic [NCH-1:0]                       flags,
    output logic [NCH-1:0]                       ctrl_wr,
    output logic [NCH-1:0]                       cmp_wr,
    output logic [DW-1:0]                        bus_rdata
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    logic [NCH-1:0] ctrl_hit;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam logic [AW-1:0] CTRL_A = AW'(CH_BASE + i * CH_STRIDE);
        localparam logic [AW-1:0] CMP_A  = AW'(CH_BASE + i * CH_STRIDE + 4);
        assign ctrl_hit[i] = (bus_addr == CTRL_A);
        assign ctrl_wr[i]  = bus_wr && ctrl_hit[i];
        assign cmp_wr[i]   = bus_wr && (bus_addr == CMP_A);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_A) begin
            bus_rdata = DW'(flags);
        end
        for (int i = 0; i < NCH; i++) begin
            if (ctrl_hit[i]) begin
                bus_rdata = DW'(ctrl_rd[i]);
            end
        end
    end

    // R1: one address never selects more than one register
    assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr, cmp_wr}));

endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
    parameter int CW = 31
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CW-1:0]                   cnt_i,
    input  logic                            ctrl_wr,
    input  logic                            cmp_wr,
    input  logic [CW-1:0]                   data,
    output logic [oc_timer_pkg::CTRL_W-1:0] ctrl_rd,
    output logic                            flag_o,
    output logic                            pin_o,
    output logic                            irq_o
);
    import oc_timer_pkg::*;

    typedef struct packed {
        logic          dre;
        logic          ie;
        logic [3:0]    mode;
        logic          flag;
        logic          pin;
        logic [CW-1:0] tgt;
        logic          tgt_v;
        logic [CW-1:0] queued;
        logic          queued_v;
    } chan_t;

    chan_t st_q, st_d;
    logic  match;
    logic  unused_rsvd;

    assign unused_rsvd = ^{data[CW-1:CTRL_W], data[1]};

    always_comb begin
        st_d  = st_q;
        match = (st_q.mode != MODE_OFF) && st_q.tgt_v && (cnt_i == st_q.tgt);

        if (match) begin
            if (st_q.queued_v) begin
                st_d.tgt      = st_q.queued;
                st_d.queued_v = 1'b0;
            end else begin
                st_d.tgt_v = 1'b0;
            end
        end

        if (cmp_wr) begin
            if (st_q.mode == MODE_OFF) begin
                st_d.tgt      = data;
                st_d.tgt_v    = 1'b1;
                st_d.queued_v = 1'b0;
            end else if (!st_d.tgt_v) begin
                st_d.tgt   = data;
                st_d.tgt_v = 1'b1;
            end else begin
                st_d.queued   = data;
                st_d.queued_v = 1'b1;
            end
        end

        if (ctrl_wr) begin
            st_d.dre  = data[BIT_DRE];
            st_d.ie   = data[BIT_IE];
            st_d.mode = data[MODE_HI:MODE_LO];
            if (data[BIT_FLAG]) begin
                st_d.flag = 1'b0;
            end
            if (st_d.mode == MODE_OFF) begin
                st_d.queued_v = 1'b0;
            end
        end

        if (match) begin
            st_d.flag = 1'b1;
        end

        if (st_d.mode == MODE_OFF) begin
            st_d.pin = 1'b0;
        end else begin
            case (st_q.mode)
                MODE_PULSE:  st_d.pin = match;
                MODE_TOGGLE: st_d.pin = st_q.pin ^ match;
                default:     st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_rd = {st_q.flag, st_q.ie, st_q.mode, 1'b0, st_q.dre};
    assign flag_o  = st_q.flag;
    assign pin_o   = st_q.pin;
    assign irq_o   = st_q.flag && st_q.ie;

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.flag);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && !st_q.flag) |=> !st_q.flag);

    assert_pulse_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pin && st_q.mode == MODE_PULSE && $past(st_q.mode) == MODE_PULSE) |-> st_q.flag);

    assert_toggle_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TOGGLE && $past(st_q.mode) == MODE_TOGGLE && st_q.pin != $past(st_q.pin))
        |-> $past(match));

    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !st_q.queued_v && !cmp_wr) |=> !st_q.tgt_v);

    assert_queue_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !ctrl_wr && st_q.mode != MODE_OFF && st_q.tgt_v && !match) |=> st_q.queued_v);

endmodule

// File: rtl/oc_timer_bank.sv
module oc_timer_bank #(
    parameter int NCH       = 4,
    parameter int CW        = 31,
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int STAT_ADDR = 4,
    parameter int CH_BASE   = 8,
    parameter int CH_STRIDE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_i,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] cmp_pin_o,
    output logic [NCH-1:0] irq_o
);
    import oc_timer_pkg::*;

    logic [NCH-1:0][CTRL_W-1:0] ctrl_rd;
    logic [NCH-1:0]             flags;
    logic [NCH-1:0]             ctrl_wr;
    logic [NCH-1:0]             cmp_wr;
    logic                       unused_wbits;

    assign unused_wbits = ^bus_wdata[DW-1:CW];

    oc_bus_decode #(
        .NCH(NCH), .AW(AW), .DW(DW),
        .STAT_ADDR(STAT_ADDR), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .ctrl_rd(ctrl_rd), .flags(flags),
        .ctrl_wr(ctrl_wr), .cmp_wr(cmp_wr),
        .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        oc_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
            .ctrl_wr(ctrl_wr[i]), .cmp_wr(cmp_wr[i]),
            .data(bus_wdata[CW-1:0]),
            .ctrl_rd(ctrl_rd[i]), .flag_o(flags[i]),
            .pin_o(cmp_pin_o[i]), .irq_o(irq_o[i])
        );

        assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[i] |-> ctrl_rd[i][BIT_FLAG] && ctrl_rd[i][BIT_IE]);
    end

endmodule

// File: tb/oc_timer_bank_bench.sv
module oc_timer_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] cnt_i = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cmp_pin_o;
    logic [3:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    oc_timer_bank u_oc_timer_bank (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_pin_o(cmp_pin_o), .irq_o(irq_o)
    );

    // wr, addr, wdata, cnt, chk_addr, exp_rd, exp_pin, exp_irq
    localparam int NV = 33;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h08, 16'h0000, 16'd7,   8'h08, 16'h0000, 4'b0000, 4'b0000}, // R1 off
        {1'b1, 8'h0C, 16'd100,  16'd7,   8'h04, 16'h0000, 4'b0000, 4'b0000}, // R7 disabled write
        {1'b1, 8'h08, 16'h007C, 16'd7,   8'h08, 16'h007C, 4'b0000, 4'b0000}, // R1 pulse+ie
        {1'b1, 8'h0C, 16'd200,  16'd7,   8'h04, 16'h0000, 4'b0000, 4'b0000}, // R7 queued
        {1'b0, 8'h00, 16'h0000, 16'd100, 8'h08, 16'h00FC, 4'b0001, 4'b0001}, // R3 R5 match
        {1'b0, 8'h00, 16'h0000, 16'd101, 8'h04, 16'h0001, 4'b0000, 4'b0001}, // R5 R2
        {1'b1, 8'h08, 16'h00FC, 16'd102, 8'h08, 16'h007C, 4'b0000, 4'b0000}, // R3 clear R4
        {1'b0, 8'h00, 16'h0000, 16'd200, 8'h04, 16'h0001, 4'b0001, 4'b0001}, // R8 promoted
        {1'b0, 8'h00, 16'h0000, 16'd201, 8'h08, 16'h00FC, 4'b0000, 4'b0001}, // R5
        {1'b1, 8'h08, 16'h00FC, 16'd200, 8'h04, 16'h0000, 4'b0000, 4'b0000}, // R8 no repeat
        {1'b1, 8'h14, 16'd50,   16'd7,   8'h04, 16'h0000, 4'b0000, 4'b0000}, // R7
        {1'b1, 8'h10, 16'h0014, 16'd7,   8'h10, 16'h0014, 4'b0000, 4'b0000}, // R1 toggle
        {1'b1, 8'h14, 16'd60,   16'd7,   8'h04, 16'h0000, 4'b0000, 4'b0000}, // R7 queued
        {1'b0, 8'h00, 16'h0000, 16'd50,  8'h04, 16'h0002, 4'b0010, 4'b0000}, // R6 R4
        {1'b0, 8'h00, 16'h0000, 16'd55,  8'h10, 16'h0094, 4'b0010, 4'b0000}, // R6 hold
        {1'b0, 8'h00, 16'h0000, 16'd60,  8'h04, 16'h0002, 4'b0000, 4'b0000}, // R6 R8
        {1'b1, 8'h10, 16'h0080, 16'd7,   8'h10, 16'h0000, 4'b0000, 4'b0000}, // R9 off
        {1'b1, 8'h14, 16'd70,   16'd7,   8'h04, 16'h0000, 4'b0000, 4'b0000}, // R7
        {1'b0, 8'h00, 16'h0000, 16'd70,  8'h04, 16'h0000, 4'b0000, 4'b0000}, // R9 no match
        {1'b1, 8'h10, 16'h0054, 16'd7,   8'h10, 16'h0054, 4'b0000, 4'b0000}, // R1
        {1'b0, 8'h00, 16'h0000, 16'd70,  8'h04, 16'h0002, 4'b0010, 4'b0010}, // R6 R4
        {1'b1, 8'h18, 16'h0003, 16'd7,   8'h18, 16'h0001, 4'b0010, 4'b0010}, // R1 reserved bit
        {1'b1, 8'h24, 16'd300,  16'd7,   8'h04, 16'h0002, 4'b0010, 4'b0010}, // R7
        {1'b1, 8'h20, 16'h003C, 16'd7,   8'h20, 16'h003C, 4'b0010, 4'b0010}, // R1
        {1'b1, 8'h24, 16'd400,  16'd7,   8'h04, 16'h0002, 4'b0010, 4'b0010}, // R7 queued
        {1'b1, 8'h20, 16'h0000, 16'd7,   8'h20, 16'h0000, 4'b0010, 4'b0010}, // R9 discard
        {1'b1, 8'h20, 16'h003C, 16'd7,   8'h20, 16'h003C, 4'b0010, 4'b0010}, // R1
        {1'b0, 8'h00, 16'h0000, 16'd300, 8'h04, 16'h000A, 4'b1010, 4'b0010}, // R5 R2
        {1'b0, 8'h00, 16'h0000, 16'd400, 8'h04, 16'h000A, 4'b0010, 4'b0010}, // R9 queue gone
        {1'b1, 8'h0C, 16'd500,  16'd7,   8'h04, 16'h000A, 4'b0010, 4'b0010}, // R7 arm
        {1'b1, 8'h08, 16'h00FC, 16'd500, 8'h08, 16'h00FC, 4'b0011, 4'b0011}, // R3 set wins
        {1'b0, 8'h00, 16'h0000, 16'd501, 8'h04, 16'h000B, 4'b0010, 4'b0011}, // R2
        {1'b0, 8'h00, 16'h0000, 16'd7,   8'h0C, 16'h0000, 4'b0010, 4'b0011}  // R1 cmp reads 0
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle(logic wr, logic [7:0] a, logic [31:0] d, logic [30:0] c);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_i = c;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 pins", {28'b0, cmp_pin_o}, 32'h0);
        check("R10 irq", {28'b0, irq_o}, 32'h0);
        for (int c = 0; c < 4; c++) rd_check("R10 ctrl", 8'(8 + 8 * c), 32'h0);
        rd_check("R10 status", 8'h04, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [72:0] e;
            e = VEC[v];
            cycle(e[72], e[71:64], {16'h0, e[63:48]}, {15'h0, e[47:32]});
            check($sformatf("vec %0d pin R5/R6", v), {28'b0, cmp_pin_o}, {28'b0, e[7:4]});
            check($sformatf("vec %0d irq R4", v), {28'b0, irq_o}, {28'b0, e[3:0]});
            rd_check($sformatf("vec %0d read R1/R2/R3", v), e[31:24], {16'h0, e[23:8]});
        end

        // R10 reset from a busy state
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R10 pins after reset", {28'b0, cmp_pin_o}, 32'h0);
        check("R10 irq after reset", {28'b0, irq_o}, 32'h0);
        rd_check("R10 status after reset", 8'h04, 32'h0);
        rd_check("R10 ctrl1 after reset", 8'h10, 32'h0);
        // R10 previously armed target is gone
        cycle(1'b1, 8'h28, 32'h3C, 31'd7);
        cycle(1'b0, 8'h00, 32'h0, 31'd500);
        rd_check("R10 no stale target", 8'h04, 32'h0);

        // R7 queued value is overwritten by a later write; R8 ordering
        cycle(1'b1, 8'h1C, 32'd10, 31'd7);
        cycle(1'b1, 8'h18, 32'h3C, 31'd7);
        cycle(1'b1, 8'h1C, 32'd20, 31'd7);
        cycle(1'b1, 8'h1C, 32'd30, 31'd7);
        cycle(1'b0, 8'h00, 32'h0, 31'd10);
        check("R8 first target", {28'b0, cmp_pin_o}, 32'h4);
        cycle(1'b0, 8'h00, 32'h0, 31'd20);
        check("R7 overwritten queue", {28'b0, cmp_pin_o}, 32'h0);
        cycle(1'b0, 8'h00, 32'h0, 31'd30);
        check("R7 latest queue", {28'b0, cmp_pin_o}, 32'h4);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule